// File: doc/BRIEF.md
# EEPROM Page Programming Controller

This block sits on the host side of a byte-wide parallel EEPROM and programs one page per request. A start pulse supplies a page number and a byte count. The controller then takes the bytes from a local buffer over a valid/ready stream. Each byte becomes one write strobe on the memory pins: chip enable, output enable, write enable, a 15-bit address and an 8-bit data bus split into output, output-enable and input. When the protected-write mode is asked for, the controller first issues the three-byte unlock prefix. The prefix uses the same strobe timing as the data and falls inside the same byte-load window.

After the last byte, the controller releases the data bus and reads back the last written address over and over. It has two ways to detect the end of programming. In data-polling mode it compares bit 7 of each read with bit 7 of the last byte written. In toggle mode it waits until bit 6 reads the same on two reads in a row. It pulses `done` when programming ends. If the byte stream stalls past the load window, or polling runs past the worst-case write time, it raises `timeout_err` and returns to idle.

All pin timings are given in nanoseconds or microseconds and are converted to whole clock cycles, rounded up, from the `CLK_HZ` parameter. The stream follows these rules. `wr_ready` is high only while the controller waits for the next byte. A byte moves on a clock edge where `wr_valid` and `wr_ready` are both high. The source may hold `wr_valid` low for as long as it needs, but no longer than the load window once the first strobe of the job has been issued.

Top module: `page_prog_ctrl`

## Requirements
- R1: During and after reset, and whenever the controller is idle, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, and `wr_ready`, `busy`, `done` and `timeout_err` are 0 (except `timeout_err` after an error, per R12).
- R2: Data byte i of a job (i = 0 .. byte_count-1, in stream order) is written to address {page, i[5:0]}: bits 14..6 carry the page and bits 5..0 the offset. Exactly byte_count data strobes are issued, for byte_count from 1 to 64.
- R3: Each write strobe holds `mem_we_n` low for at least ceil(WP_NS·CLK_HZ/1e9) cycles (5 at 50 MHz). Between strobes `mem_we_n` stays high for at least ceil(WPH_NS·CLK_HZ/1e9) cycles (3). Address and data stay stable while the strobe is low.
- R4: `mem_oe_n` is 1 whenever `mem_we_n` and `mem_ce_n` are both 0. `mem_dq_oe` is 0 whenever `mem_oe_n` is 0, and also in the cycle before `mem_oe_n` falls.
- R5: With `use_prefix`=1, the data strobes are preceded by three strobes, in this order: data AA at address 5555, then 55 at 2AAA, then A0 at 5555 (hex). With `use_prefix`=0 there is no prefix.
- R6: `wr_ready` is high only while the controller waits for a data byte. Each handshake consumes exactly one byte, and any gap in `wr_valid` within the load window has no effect on the result.
- R7: If no byte is accepted within BLC_US microseconds (rounded to cycles) of the previous strobe's rising edge, `timeout_err` is set, the job stops without `done`, and all strobes are released.
- R8: With `poll_toggle`=0, after the last strobe the controller reads the last written address with `mem_oe_n` low, and finishes when bit 7 of a read equals bit 7 of the last data byte.
- R9: With `poll_toggle`=1, the controller finishes when bit 6 has the same value on two consecutive reads.
- R10: If polling has not finished TWC_US microseconds (rounded to cycles) after it begins, `timeout_err` is set, no `done` is given, and all strobes are released.
- R11: `done` is a one-cycle pulse. `busy` is high from the cycle after an accepted start until the job ends. A start while busy is ignored.
- R12: `timeout_err` stays set until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start-of-job pulse, taken only when idle |
| page | input | 9 | Page number (address bits 14..6) |
| byte_count | input | 7 | Number of data bytes, 1 to 64 |
| use_prefix | input | 1 | Send the three-byte unlock prefix first |
| poll_toggle | input | 1 | 0: bit-7 data polling, 1: bit-6 toggle polling |
| wr_data | input | 8 | Stream data byte |
| wr_valid | input | 1 | Stream data valid |
| wr_ready | output | 1 | Controller can take a byte |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Data read from the memory bus |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse when programming has finished |
| timeout_err | output | 1 | Load-window or polling timeout occurred |

## Verification
Jobs cover single-byte and full 64-byte pages, the lowest and highest page numbers, both poll modes, and runs with and without the prefix. Each job sees random stream gaps and random programming times from a memory model. That model returns inverted bit 7 and a flipping bit 6 while it is busy. Because of this, a controller that finishes on the wrong bit, or on the first read, is caught by comparing the `done` cycle with the model's commit cycle. Extra cases separate the two timeout paths: a programming time longer than the polling limit, and a stream that stops after three bytes. A start pulsed in the middle of a job checks that the latched page stays in use. A job run right after an error checks that the error flag clears on the next start.

// File: rtl/prog_pkg.sv
package prog_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_LOAD, ST_SET, ST_STRB, ST_HOLD, ST_REL, ST_RD, ST_GAP
  } prog_st_e;

  // duration in ns -> whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input longint ns, input longint hz);
    longint c;
    c = (ns * hz + 64'sd999_999_999) / 64'sd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // unlock prefix: step 0 and 2 hit 5555, step 1 hits 2AAA
  function automatic logic [14:0] pre_addr(input logic [1:0] step);
    return (step == 2'd1) ? 15'h2AAA : 15'h5555;
  endfunction

  function automatic logic [7:0] pre_data(input logic [1:0] step);
    case (step)
      2'd0:    return 8'hAA;
      2'd1:    return 8'h55;
      default: return 8'hA0;
    endcase
  endfunction

endpackage

// File: rtl/prog_cycle_timer.sv
module prog_cycle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/prog_poll_eval.sv
module prog_poll_eval (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic stb,
  input  logic toggle_mode,
  input  logic ref_b7,
  input  logic b7,
  input  logic b6,
  output logic hit
);
  logic have_prev, prev_b6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_b6   <= 1'b0;
      hit       <= 1'b0;
    end else if (clear) begin
      have_prev <= 1'b0;
      hit       <= 1'b0;
    end else if (stb) begin
      hit       <= toggle_mode ? (have_prev && (b6 == prev_b6)) : (b7 == ref_b7);
      prev_b6   <= b6;
      have_prev <= 1'b1;
    end
  end

  // toggle completion needs two reads since the poll phase began
  AST_TOGGLE_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && toggle_mode && !have_prev) |=> !hit); // R9
endmodule

// File: rtl/page_prog_ctrl.sv
module page_prog_ctrl #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int WP_NS      = 100,
  parameter int WPH_NS     = 50,
  parameter int RD_NS      = 90,
  parameter int OEH_NS     = 150,
  parameter int BLC_US     = 150,
  parameter int TWC_US     = 10_000,
  parameter int AW         = 15,
  parameter int DW         = 8,
  parameter int PAGE_BYTES = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic [AW-$clog2(PAGE_BYTES)-1:0]  page,
  input  logic [$clog2(PAGE_BYTES):0]       byte_count,
  input  logic                              use_prefix,
  input  logic                              poll_toggle,
  input  logic [DW-1:0]                     wr_data,
  input  logic                              wr_valid,
  output logic                              wr_ready,
  output logic                              mem_ce_n,
  output logic                              mem_oe_n,
  output logic                              mem_we_n,
  output logic [AW-1:0]                     mem_addr,
  output logic [DW-1:0]                     mem_dq_out,
  output logic                              mem_dq_oe,
  input  logic [DW-1:0]                     mem_dq_in,
  output logic                              busy,
  output logic                              done,
  output logic                              timeout_err
);
  import prog_pkg::*;

  localparam int OW      = $clog2(PAGE_BYTES);
  localparam int PW      = AW - OW;
  localparam int CW      = OW + 1;
  localparam int WP_CYC  = ns_to_cyc(longint'(WP_NS),  longint'(CLK_HZ));
  localparam int WPH_CYC = ns_to_cyc(longint'(WPH_NS), longint'(CLK_HZ));
  localparam int RD_CYC  = ns_to_cyc(longint'(RD_NS),  longint'(CLK_HZ));
  localparam int OEH_CYC = ns_to_cyc(longint'(OEH_NS), longint'(CLK_HZ));
  localparam int BLC_CYC = ns_to_cyc(longint'(BLC_US) * 1000, longint'(CLK_HZ));
  localparam int TWC_CYC = ns_to_cyc(longint'(TWC_US) * 1000, longint'(CLK_HZ));
  localparam int PHW     = $clog2(max2(max2(WP_CYC, WPH_CYC), max2(RD_CYC, OEH_CYC)) + 1);
  localparam int LW      = $clog2(max2(BLC_CYC, TWC_CYC) + 1);

  prog_st_e       st, nx;
  logic [PW-1:0]  page_r;
  logic [CW-1:0]  cnt_r;
  logic [OW-1:0]  idx_r;
  logic [1:0]     pre_idx;
  logic           pre_on, tog_r, wrote_any, done_r, err_r;
  logic [AW-1:0]  addr_r;
  logic [DW-1:0]  data_r;
  logic           ph_load, ph_exp, lt_load, lt_exp, hit;
  logic [PHW-1:0] ph_val;
  logic [LW-1:0]  lt_val;
  logic           accept, last_byte, load_late, poll_late, finish;
  logic           unused_dq;

  assign accept    = (st == ST_LOAD) && wr_valid;
  assign last_byte = ({1'b0, idx_r} == (cnt_r - CW'(1)));
  assign load_late = (st == ST_LOAD) && wrote_any && lt_exp && !wr_valid;
  assign finish    = (st == ST_GAP) && ph_exp && hit;
  assign poll_late = lt_exp && ((st == ST_RD) || ((st == ST_GAP) && !finish));
  assign unused_dq = ^mem_dq_in[DW-3:0];

  always_comb begin
    nx = st;
    unique case (st)
      ST_IDLE: if (start) nx = use_prefix ? ST_PRE : ST_LOAD;
      ST_PRE:  nx = ST_SET;
      ST_LOAD: if (accept) nx = ST_SET; else if (load_late) nx = ST_IDLE;
      ST_SET:  nx = ST_STRB;
      ST_STRB: if (ph_exp) nx = ST_HOLD;
      ST_HOLD: if (ph_exp) begin
                 if (pre_on) nx = (pre_idx == 2'd2) ? ST_LOAD : ST_PRE;
                 else        nx = last_byte ? ST_REL : ST_LOAD;
               end
      ST_REL:  nx = ST_RD;
      ST_RD:   if (poll_late) nx = ST_IDLE; else if (ph_exp) nx = ST_GAP;
      ST_GAP:  if (finish || poll_late) nx = ST_IDLE; else if (ph_exp) nx = ST_RD;
      default: nx = ST_IDLE;
    endcase
  end

  // phase timer reloads on every state change with the length of the state entered
  always_comb begin
    unique case (nx)
      ST_STRB: ph_val = PHW'(WP_CYC - 1);
      ST_HOLD: ph_val = PHW'(WPH_CYC - 1);
      ST_RD:   ph_val = PHW'(RD_CYC - 1);
      ST_GAP:  ph_val = PHW'(OEH_CYC - 1);
      default: ph_val = '0;
    endcase
  end
  assign ph_load = (nx != st);
  assign lt_load = ((st == ST_STRB) && (nx == ST_HOLD)) || (nx == ST_REL);
  assign lt_val  = (nx == ST_REL) ? LW'(TWC_CYC - 1) : LW'(BLC_CYC - 1);

  prog_cycle_timer #(.W(PHW)) u_ph_tmr (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .val(ph_val), .expired(ph_exp));
  prog_cycle_timer #(.W(LW)) u_lt_tmr (
    .clk(clk), .rst_n(rst_n), .load(lt_load), .val(lt_val), .expired(lt_exp));

  prog_poll_eval u_eval (
    .clk(clk), .rst_n(rst_n), .clear(st == ST_REL), .stb((st == ST_RD) && ph_exp),
    .toggle_mode(tog_r), .ref_b7(data_r[DW-1]), .b7(mem_dq_in[DW-1]),
    .b6(mem_dq_in[DW-2]), .hit(hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  page_r <= '0; cnt_r <= '0; idx_r <= '0; pre_idx <= '0;
      pre_on <= 1'b0; tog_r <= 1'b0; wrote_any <= 1'b0;
      addr_r <= '0;   data_r <= '0; done_r <= 1'b0; err_r <= 1'b0;
    end else begin
      st     <= nx;
      done_r <= finish;
      if (load_late || poll_late) err_r <= 1'b1;
      unique case (st)
        ST_IDLE: if (start) begin
          page_r <= page; cnt_r <= byte_count; pre_on <= use_prefix;
          tog_r <= poll_toggle; pre_idx <= '0; idx_r <= '0;
          wrote_any <= 1'b0; err_r <= 1'b0;
        end
        ST_PRE: begin
          addr_r <= AW'(pre_addr(pre_idx));
          data_r <= DW'(pre_data(pre_idx));
        end
        ST_LOAD: if (accept) begin
          addr_r <= {page_r, idx_r};
          data_r <= wr_data;
        end
        ST_STRB: if (ph_exp) wrote_any <= 1'b1;
        ST_HOLD: if (ph_exp) begin
          if (pre_on) begin
            if (pre_idx == 2'd2) pre_on <= 1'b0;
            else                 pre_idx <= pre_idx + 2'd1;
          end else if (!last_byte) begin
            idx_r <= idx_r + OW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_ready    = (st == ST_LOAD);
  assign mem_ce_n    = (st == ST_IDLE);
  assign mem_we_n    = (st != ST_STRB);
  assign mem_oe_n    = (st != ST_RD);
  assign mem_dq_oe   = (st == ST_SET) || (st == ST_STRB) || (st == ST_HOLD);
  assign mem_addr    = addr_r;
  assign mem_dq_out  = data_r;
  assign busy        = (st != ST_IDLE);
  assign done        = done_r;
  assign timeout_err = err_r;

  // pin-level counters used only by the checks below
  logic [7:0] we_lo, we_hi;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo <= '0; we_hi <= '0;
    end else begin
      we_lo <= mem_we_n ? 8'd0 : ((we_lo == 8'hFF) ? we_lo : we_lo + 8'd1);
      we_hi <= !mem_we_n ? 8'd0 : ((we_hi == 8'hFF) ? we_hi : we_hi + 8'd1);
    end
  end

  AST_OE_HIGH_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !mem_ce_n) |-> mem_oe_n); // R4
  AST_BUS_FREE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> (!mem_dq_oe && !$past(mem_dq_oe))); // R4
  AST_WE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($past(we_lo) >= 8'(WP_CYC - 1))); // R3
  AST_WE_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_we_n) && wrote_any) |-> ($past(we_hi) >= 8'(WPH_CYC - 1))); // R3
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !pre_on) |-> (mem_addr[AW-1:OW] == page_r)); // R2
  AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$rose(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> !done); // R10
  AST_READY_ONLY_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (mem_we_n && !mem_dq_oe && mem_oe_n)); // R6
endmodule

// File: tb/page_prog_ctrl_bench.sv
module page_prog_ctrl_bench;
  localparam int WP_E  = 5;     // 100 ns at 20 ns
  localparam int WPH_E = 3;     // 50 ns
  localparam int BLC_E = 200;   // 4 us
  localparam int TWC_E = 1000;  // 20 us

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, use_prefix = 0, poll_toggle = 0, wr_valid = 0;
  logic [8:0] page = '0;
  logic [6:0] byte_count = '0;
  logic [7:0] wr_data = '0;
  logic wr_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, busy, done, timeout_err;
  logic [14:0] mem_addr;
  logic [7:0] mem_dq_out, mem_dq_in;

  always #10 clk = ~clk;

  page_prog_ctrl #(.BLC_US(4), .TWC_US(20)) u_page_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .page(page), .byte_count(byte_count),
    .use_prefix(use_prefix), .poll_toggle(poll_toggle), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .busy(busy), .done(done),
    .timeout_err(timeout_err));

  int n_tests = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [22:0] wlog[$];
  logic [7:0]  pmem [64];
  logic [7:0]  rd_val = 8'h00;
  logic [14:0] lat_a, last_a;
  logic [7:0]  lat_d, last_d;
  int  cyc = 0, busy_cnt = 0, prog_cyc = 100, commit_cyc = 0, done_cyc = 0, last_rise = 0;
  int  we_lo = 0, we_hi = 0, short_lo = 0, short_hi = 0, bad_bus = 0, done_cnt = 0, dbl_done = 0;
  bit  tog = 0, p_we = 1, p_oe = 1, p_dqoe = 0, p_done = 0;
  int  acc = 0;

  assign mem_dq_in = rd_val;

  always @(posedge clk) if (wr_valid && wr_ready) acc <= acc + 1;

  always @(negedge clk) begin
    cyc++;
    if (busy_cnt > 0) begin
      busy_cnt--;
      if (busy_cnt == 0) commit_cyc = cyc;
    end
    if (!mem_we_n && !mem_ce_n) begin
      we_lo++; lat_a = mem_addr; lat_d = mem_dq_out;
      if (!mem_oe_n || !mem_dq_oe) bad_bus++;
    end
    if (!mem_we_n && p_we && wlog.size() > 0 && we_hi < WPH_E) short_hi++;
    if (mem_we_n && !p_we) begin
      if (we_lo < WP_E) short_lo++;
      wlog.push_back({lat_a, lat_d});
      pmem[lat_a[5:0]] = lat_d; last_a = lat_a; last_d = lat_d;
      busy_cnt = prog_cyc; last_rise = cyc; we_lo = 0; we_hi = 0;
    end
    if (mem_we_n) we_hi++;
    if (!mem_oe_n && (mem_dq_oe || p_dqoe)) bad_bus++;
    if (!mem_oe_n && p_oe) begin
      if (busy_cnt > 0) begin
        rd_val = {~last_d[7], tog, last_d[5:0]}; tog = !tog;
      end else rd_val = pmem[mem_addr[5:0]];
    end
    if (done) begin done_cnt++; done_cyc = cyc; if (p_done) dbl_done++; end
    p_we = mem_we_n; p_oe = mem_oe_n; p_dqoe = mem_dq_oe; p_done = done;
  end

  // ---------------- stimulus ----------------
  logic [7:0] bytes [64];
  int feed_n = 0; bit feed_poke = 0; logic [8:0] feed_pg = '0;

  task automatic feed();
    for (int i = 0; i < feed_n; i++) begin
      int w;
      repeat ($urandom % 4) @(negedge clk);
      wr_valid = 1'b1; wr_data = bytes[i];
      w = 0;
      while (!wr_ready && w < 3000) begin @(negedge clk); w++; end
      @(posedge clk); @(negedge clk);
      wr_valid = 1'b0;
      if (feed_poke && i == 0) begin
        start = 1'b1; page = feed_pg ^ 9'h1;
        @(negedge clk);
        start = 1'b0; page = feed_pg;
      end
    end
  endtask

  function automatic logic [22:0] exp_entry(input int k, input bit pre, input logic [8:0] pg);
    if (pre && k == 0) return {15'h5555, 8'hAA};
    if (pre && k == 1) return {15'h2AAA, 8'h55};
    if (pre && k == 2) return {15'h5555, 8'hA0};
    return {pg, 6'(k - (pre ? 3 : 0)), bytes[k - (pre ? 3 : 0)]};
  endfunction

  // kind: 0 normal, 1 polling timeout, 2 stalled stream
  task automatic run_job(input logic [8:0] pg, input int cnt, input bit pre, input bit tgl,
                         input int prog, input int kind, input bit poke);
    int w, base, give, err_cyc, nmis;
    bit saw_done;
    string pr;
    pr = tgl ? "R9" : "R8";
    for (int i = 0; i < 64; i++) bytes[i] = 8'($urandom);
    give = (kind == 2) ? 3 : cnt;
    prog_cyc = prog; wlog.delete(); commit_cyc = 0; done_cyc = 0;
    short_lo = 0; short_hi = 0; bad_bus = 0; done_cnt = 0; dbl_done = 0;
    base = acc;
    @(negedge clk);
    page = pg; byte_count = 7'(cnt); use_prefix = pre; poll_toggle = tgl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11", "busy after start", busy, 1);
    chk(timeout_err == 1'b0, "R12", "error cleared by start", timeout_err, 0);
    feed_n = give; feed_poke = poke; feed_pg = pg;
    fork feed(); join_none
    w = 0;
    while (!(done || timeout_err) && w < 30000) begin @(negedge clk); w++; end
    saw_done = done; err_cyc = cyc;
    wait fork;
    repeat (4) @(negedge clk);
    if (kind == 0) begin
      chk(saw_done && !timeout_err, pr, "job finished with done", {saw_done, timeout_err}, 2'b10);
      chk(done_cyc > commit_cyc, pr, "done not before program end", done_cyc, commit_cyc);
      chk(done_cyc - commit_cyc <= 60, pr, "done latency after program end", done_cyc - commit_cyc, 60);
      chk(acc - base == cnt, "R6", "bytes consumed", acc - base, cnt);
    end else begin
      chk(!saw_done && timeout_err && done_cnt == 0, (kind == 1) ? "R10" : "R7",
          "error without done", {done_cnt[3:0], timeout_err}, 1);
      if (kind == 1)
        chk(err_cyc - last_rise >= TWC_E && err_cyc - last_rise <= TWC_E + 100, "R10",
            "poll timeout delay", err_cyc - last_rise, TWC_E);
      else
        chk(err_cyc - last_rise >= BLC_E - 10 && err_cyc - last_rise <= BLC_E + 30, "R7",
            "load window delay", err_cyc - last_rise, BLC_E);
    end
    chk(wlog.size() == (pre ? 3 : 0) + give, pre ? "R5" : "R2", "strobe count",
        wlog.size(), (pre ? 3 : 0) + give);
    nmis = 0;
    foreach (wlog[k]) if (wlog[k] !== exp_entry(k, pre, pg)) nmis++;
    chk(nmis == 0, pre ? "R5" : "R2", "strobe address/data order", nmis, 0);
    chk(short_lo == 0 && short_hi == 0, "R3", "strobe widths", short_lo + short_hi, 0);
    chk(bad_bus == 0, "R4", "bus contention events", bad_bus, 0);
    chk(dbl_done == 0 && done_cnt <= 1, "R11", "done pulse count", done_cnt, kind == 0);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !busy && !wr_ready, "R1",
        "idle pins after job", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, busy}, 5'b11100);
    chk(timeout_err == (kind != 0), "R12", "error flag held", timeout_err, kind != 0);
    while (busy_cnt > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog act=%0d exp=%0d", 190000, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C1A));
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !busy && !done && !timeout_err
        && !wr_ready, "R1", "pins in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !busy, "R1", "pins after reset",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    run_job(9'h000, 1,  0, 0, 150,  0, 0);  // single byte, data poll
    run_job(9'h0A5, 64, 1, 1, 300,  0, 0);  // full page, prefix, toggle
    run_job(9'h133, 64, 0, 0, 200,  0, 1);  // start pulsed mid-job (R11)
    run_job(9'h1FF, 1,  1, 1, 120,  0, 0);  // top page, prefix, toggle
    run_job(9'h044, 4,  0, 0, 5000, 1, 0);  // polling timeout, data mode
    run_job(9'h045, 5,  0, 1, 180,  0, 0);  // recovery after error (R12)
    run_job(9'h0F0, 8,  1, 0, 200,  2, 0);  // stream stalls after three bytes
    run_job(9'h101, 3,  0, 1, 5000, 1, 0);  // polling timeout, toggle mode
    for (int t = 0; t < 10; t++)
      run_job(9'($urandom), 1 + int'($urandom % 64), 1'($urandom), 1'($urandom),
              50 + int'($urandom % 450), 0, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule